// File: doc/BRIEF.md
# Four-Channel Stepped-Duty PWM Driver

This block drives four actuator channels, one per quadrant direction, each with an on/off pulse-width-modulated output. Every channel takes a 3-bit level that picks one of eight fixed duty cycles. The duty cycles rise in 15% steps from 0% to 90%, and the top level holds the output on all the time. All four channels compare against one free-running 8-bit counter, so their periods share a phase.

New levels go through a two-stage register. A load strobe copies all four level inputs into a pending stage at any time. The active levels, which set the duty, take the pending values only when the counter wraps. A period that has started is therefore never cut short or stretched.

Top module: `quad_pwm_driver`

## Requirements
- R1: One 8-bit counter, shared by all channels, starts at 0 after reset, counts up by one each clock and wraps from 255 to 0, so every period is 256 clocks long.
- R2: Active levels 0..7 map to high-time thresholds of 0, 38, 77, 115, 154, 192, 230 and 256 counter ticks. These are the levels times 15% of 256, rounded, with level 7 forced to the full period.
- R3: A channel at level 0 holds its output low for the whole period.
- R4: A channel at level 7 holds its output high continuously, across the wrap as well.
- R5: Each output is registered and is high in exactly those cycles whose counter value is below the channel's threshold. Within a period it can only rise at counter value 0, and once low it stays low until the wrap.
- R6: A load strobe copies all four levels into the pending stage. The last load before the wrap wins. The output keeps following the old level for the rest of the current period.
- R7: A load strobe in the cycle where the counter is 255 goes straight into the active levels for the period that begins at 0.
- R8: While reset is asserted, all outputs are low and all pending and active levels are 0.
- R9: Channels are independent. Channel n takes bits [3n+2:3n] of the level bus and drives output bit n. The order is front, back, right, left for n = 0..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStb | input | 1 | Capture the level bus into the pending stage |
| levelIn | input | 12 | Four 3-bit levels, channel n at bits [3n+2:3n] |
| pwmOut | output | 4 | PWM outputs, bit n for channel n |

## Verification
The assertions check on every cycle that the counter wraps and increments correctly. They also check that an output rises only at counter value 0, that a low output stays low until the wrap, and that outputs are low after reset. Only the bench scenarios can show the rest:

- that each level yields its exact number of high cycles per period;
- that a mid-period load is held back until the wrap;
- that the last of several loads wins;
- that a load on the wrap cycle takes effect at once.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic wrap;   // counter is at its maximum this cycle
    logic load;   // level bus should be captured this cycle
  } pwmStrobes_t;
endpackage

// File: rtl/qpwm_ctrl.sv
module qpwm_ctrl
  import qpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadStb,
  output logic [CNT_W-1:0] cntVal,
  output pwmStrobes_t      strobes
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntVal <= '0;
    else       cntVal <= cntVal + 1'b1;
  end

  always_comb begin
    strobes.wrap = (cntVal == CNT_MAX);
    strobes.load = loadStb;
  end
endmodule

// File: rtl/qpwm_dpath.sv
module qpwm_dpath
  import qpwm_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int LVL_W    = 3,
  parameter int CNT_W    = 8,
  parameter int STEP_PCT = 15
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pwmStrobes_t             strobes,
  input  logic [CNT_W-1:0]        cntVal,
  input  logic [NUM_CH*LVL_W-1:0] levelIn,
  output logic [NUM_CH-1:0]       pwmOut
);
  localparam int THR_W   = CNT_W + 1;
  localparam int PERIOD  = 1 << CNT_W;
  localparam int LVL_TOP = (1 << LVL_W) - 1;

  // Level to high-time threshold, rounded; top level forced to full period
  function automatic logic [THR_W-1:0] lvlToThr(input logic [LVL_W-1:0] lvl);
    int raw;
    if (int'(lvl) == LVL_TOP) raw = PERIOD;
    else                      raw = (int'(lvl) * STEP_PCT * PERIOD + 50) / 100;
    if (raw > PERIOD) raw = PERIOD;
    return THR_W'(raw);
  endfunction

  logic [CNT_W-1:0] cntNext;
  assign cntNext = strobes.wrap ? '0 : cntVal + 1'b1;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [LVL_W-1:0] pendLvl;
    logic [LVL_W-1:0] actLvl;
    logic [LVL_W-1:0] actNext;
    logic [LVL_W-1:0] lvlBus;

    assign lvlBus = levelIn[ch*LVL_W +: LVL_W];

    always_comb begin
      actNext = actLvl;
      if (strobes.wrap) actNext = strobes.load ? lvlBus : pendLvl;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendLvl    <= '0;
        actLvl     <= '0;
        pwmOut[ch] <= 1'b0;
      end else begin
        if (strobes.load) pendLvl <= lvlBus;
        actLvl     <= actNext;
        pwmOut[ch] <= ({1'b0, cntNext} < lvlToThr(actNext));
      end
    end
  end
endmodule

// File: rtl/quad_pwm_driver.sv
module quad_pwm_driver
  import qpwm_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int LVL_W    = 3,
  parameter int CNT_W    = 8,
  parameter int STEP_PCT = 15
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    loadStb,
  input  logic [NUM_CH*LVL_W-1:0] levelIn,
  output logic [NUM_CH-1:0]       pwmOut
);
  logic [CNT_W-1:0] cntVal;
  pwmStrobes_t      strobes;

  qpwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadStb (loadStb),
    .cntVal  (cntVal),
    .strobes (strobes)
  );

  qpwm_dpath #(
    .NUM_CH  (NUM_CH),
    .LVL_W   (LVL_W),
    .CNT_W   (CNT_W),
    .STEP_PCT(STEP_PCT)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .cntVal  (cntVal),
    .levelIn (levelIn),
    .pwmOut  (pwmOut)
  );
endmodule

// File: rtl/qpwm_checker.sv
module qpwm_checker #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [CNT_W-1:0]  cntVal,
  input logic [NUM_CH-1:0] pwmOut
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal == CNT_MAX) |=> (cntVal == '0));

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal != CNT_MAX) |=> (cntVal == $past(cntVal) + 1'b1));

  // R8
  reset_low_chk: assert property (@(posedge clk)
    (!rstN) |=> (pwmOut == '0));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R5
    rise_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pwmOut[ch]) |-> (cntVal == '0));

    // R5
    stay_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!pwmOut[ch] && cntVal != CNT_MAX) |=> !pwmOut[ch]);
  end
endmodule

bind quad_pwm_driver qpwm_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .cntVal (cntVal),
  .pwmOut (pwmOut)
);

// File: tb/quad_pwm_driver_test.sv
`timescale 1ns/1ps
module quad_pwm_driver_test;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStb = 1'b0;
  logic [11:0] levelIn = '0;
  logic [3:0]  pwmOut;

  int checks = 0;
  int failures = 0;

  quad_pwm_driver uut (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .levelIn(levelIn), .pwmOut(pwmOut)
  );

  always #4 clk = ~clk;  // 125 MHz

  // R2 threshold list, written out from the requirement
  function automatic int thrOf(input int lvl);
    case (lvl)
      0: return 0;   1: return 38;  2: return 77;  3: return 115;
      4: return 154; 5: return 192; 6: return 230; default: return 256;
    endcase
  endfunction

  // Behavioural expectation of counter and level stages
  int mCnt = 0;
  int mPend [NCH];
  int mAct  [NCH];
  int hiCnt [NCH];
  bit fullPer = 0;

  initial for (int c = 0; c < NCH; c++) begin mPend[c] = 0; mAct[c] = 0; hiCnt[c] = 0; end

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0;
      for (int c = 0; c < NCH; c++) begin mPend[c] = 0; mAct[c] = 0; end
    end else begin
      if (mCnt == 255)
        for (int c = 0; c < NCH; c++) mAct[c] = loadStb ? int'(levelIn[c*3 +: 3]) : mPend[c];
      if (loadStb)
        for (int c = 0; c < NCH; c++) mPend[c] = int'(levelIn[c*3 +: 3]);
      mCnt = (mCnt + 1) % 256;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (mCnt == 0) fullPer = 1;
      for (int c = 0; c < NCH; c++) begin
        logic expBit;
        expBit = (mCnt < thrOf(mAct[c]));
        checks++;
        if (pwmOut[c] !== expBit) begin
          failures++;
          $display("FAIL R5 R6 R7 R9 ch%0d cnt=%0d lvl=%0d actual=%b expected=%b",
                   c, mCnt, mAct[c], pwmOut[c], expBit);
        end
        if (mCnt == 0) hiCnt[c] = 0;
        if (pwmOut[c]) hiCnt[c]++;
        if (mCnt == 255 && fullPer) begin
          checks++;
          if (hiCnt[c] != thrOf(mAct[c])) begin
            failures++;
            if (mAct[c] == 0)
              $display("FAIL R3 ch%0d high count actual=%0d expected=0", c, hiCnt[c]);
            else if (mAct[c] == 7)
              $display("FAIL R4 ch%0d high count actual=%0d expected=256", c, hiCnt[c]);
            else
              $display("FAIL R2 ch%0d lvl=%0d high count actual=%0d expected=%0d",
                       c, mAct[c], hiCnt[c], thrOf(mAct[c]));
          end
        end
      end
      // R1: every channel with a nonzero level is high together at count 0
      if (mCnt == 0) begin
        for (int c = 0; c < NCH; c++) if (mAct[c] != 0) begin
          checks++;
          if (!pwmOut[c]) begin
            failures++;
            $display("FAIL R1 ch%0d not high at period start actual=0 expected=1", c);
          end
        end
      end
    end
  end

  task automatic waitCnt(input int t);
    do @(negedge clk); while (mCnt != t);
  endtask

  task automatic loadLevels(input int l0, input int l1, input int l2, input int l3);
    loadStb = 1'b1;
    levelIn = {3'(l3), 3'(l2), 3'(l1), 3'(l0)};
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    checks++;
    if (pwmOut !== 4'b0000) begin
      failures++;
      $display("FAIL R8 outputs in reset actual=%b expected=0000", pwmOut);
    end
    rstN = 1'b1;

    // R9 independent channels, R2 sweep of every level on every channel
    for (int p = 0; p < 8; p++) begin
      waitCnt(100);
      loadLevels(p % 8, (p + 1) % 8, (p + 3) % 8, (p + 6) % 8);
    end
    // R6: two loads inside one period, the later one must win
    waitCnt(50);
    loadLevels(7, 7, 7, 7);
    waitCnt(60);
    loadLevels(2, 0, 5, 3);
    // R7: load on the wrap cycle applies at once
    waitCnt(255);
    loadLevels(6, 4, 1, 7);
    // R4 across wraps and R3 hold
    waitCnt(128);
    loadLevels(7, 0, 7, 0);
    waitCnt(0);
    waitCnt(0);
    waitCnt(0);
    waitCnt(1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule